// File: doc/BRIEF.md
# Processor-Side Channel Select Adapter

This block sits between a processor's local memory-mapped bus and a set of channel adapters that hang off an internal bus. It is the sole master of that bus. Each processor access is latched, its address is decoded to find which channel window it falls in, and exactly that channel's enable is driven for the length of the transfer. The offset within the window goes to the channels on a one-way address bus. Write data goes out on a separate lane, and read data comes back from the selected channel's lane. The processor is held with a stall signal until the transfer sequence is done. A write takes three processor cycles and a read takes seven, both counted from the cycle in which the request first appears.

A small register window placed directly above the channel windows holds an interrupt-pending register and an interrupt mask. Every channel interrupt line sets its pending bit. Software clears pending bits by writing ones to them. A single processor interrupt request is raised while any unmasked bit is pending. An access that hits neither a channel window nor a defined register returns an error and enables no channel.

Top module: `chan_select_adapter`

## Requirements
- R1: Channel i owns the address window whose upper bits `addr[AW-1:WIN_BITS]` equal i. An access in that window asserts only `ch_en[i]`, and holds it for every cycle of the transfer after the request is accepted.
- R2: At most one bit of `ch_en` is high in any cycle. An access whose upper address bits equal NCH+1 or above, or that falls in the register window at an offset other than 0 or 4, completes with `err` high in its final cycle and asserts no enable.
- R3: A write completes in exactly 3 cycles. `stall` is high in the first two cycles of the request and low in the third, and the processor holds `req` until then.
- R4: A read completes in exactly 7 cycles, with `stall` low only in the seventh. In that cycle `rdata` carries the value the selected channel drove on its `ch_rdata` lane while its enable was high.
- R5: While a channel is enabled, `ch_addr` carries the access address modulo 2^WIN_BITS, `ch_we` carries the access direction (1 = write), and `ch_wdata` carries the write data. All three stay stable for the whole transfer.
- R6: A high level on `ch_irq[i]` sets bit i of the pending register. Reading register offset 0 of the register window (upper bits equal to NCH) returns the pending bits in `rdata[NCH-1:0]`, with zeros above them.
- R7: Writing to register offset 0 clears each pending bit whose write-data bit is 1, and leaves the bits whose write-data bit is 0. A set from `ch_irq` in the same cycle wins over the clear.
- R8: `irq` is high exactly when some pending bit is set and its mask bit is 1. The mask is read and written at register offset 4, its bit i belongs to channel i, and it resets to all ones.
- R9: After reset, no enable is high, `stall`, `err` and `irq` are low, and the pending register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Processor access request, held until stall drops |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | AW | Processor byte address |
| wdata | input | DW | Processor write data |
| rdata | output | DW | Read data, valid in the final cycle of a read |
| stall | output | 1 | Wait signal to the processor |
| err | output | 1 | Decode error, high in the final cycle of the access |
| irq | output | 1 | Processor interrupt request |
| ch_en | output | NCH | One-hot channel enables |
| ch_we | output | 1 | Direction toward the channels |
| ch_addr | output | WIN_BITS | Offset within the channel window |
| ch_wdata | output | DW | Write data toward the channels |
| ch_rdata | input | NCH*DW | Read data lanes, one per channel |
| ch_irq | input | NCH | Channel interrupt lines |

## Verification
The bench builds the block with AW=8, WIN_BITS=4, NCH=4 and DW=16, so the whole address space is only 256 bytes. With these values, every channel window, the register window at 0x40, and the error space above it can all be reached by a few hand-picked addresses. Each bench channel returns a pattern made from its own index and the offset it sees. This makes a wrong decode or a wrong offset show up directly in the read data. The 16-bit data width still leaves room to check that the pending value is zero above bit NCH-1.

// File: rtl/chan_select_adapter.sv
module chan_select_adapter #(
  parameter int AW       = 16,
  parameter int DW       = 32,
  parameter int NCH      = 4,
  parameter int WIN_BITS = 8,
  parameter int WR_CYC   = 3,
  parameter int RD_CYC   = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req,
  input  logic                we,
  input  logic [AW-1:0]       addr,
  input  logic [DW-1:0]       wdata,
  output logic [DW-1:0]       rdata,
  output logic                stall,
  output logic                err,
  output logic                irq,
  output logic [NCH-1:0]      ch_en,
  output logic                ch_we,
  output logic [WIN_BITS-1:0] ch_addr,
  output logic [DW-1:0]       ch_wdata,
  input  logic [NCH*DW-1:0]   ch_rdata,
  input  logic [NCH-1:0]      ch_irq
);
  localparam int IDXW = AW - WIN_BITS;
  localparam int CW   = $clog2(RD_CYC + 1);
  localparam logic [CW-1:0] WR_LAST = CW'(WR_CYC - 2);
  localparam logic [CW-1:0] RD_LAST = CW'(RD_CYC - 2);
  localparam logic [CW-1:0] RD_CAPT = CW'(RD_CYC - 3);
  localparam logic [IDXW-1:0] REG_IDX = IDXW'(NCH);
  localparam logic [WIN_BITS-1:0] OFF_PEND = '0;
  localparam logic [WIN_BITS-1:0] OFF_MASK = WIN_BITS'(4);

  logic                busy, we_q;
  logic [CW-1:0]       cnt;
  logic [AW-1:0]       a_q;
  logic [DW-1:0]       wd_q, rd_q, sel, regval;
  logic [NCH-1:0]      pend, mask, clr;
  logic [IDXW-1:0]     idx;
  logic [WIN_BITS-1:0] off;
  logic                is_ch, is_reg, done;

  assign idx    = a_q[AW-1:WIN_BITS];
  assign off    = a_q[WIN_BITS-1:0];
  assign is_ch  = idx < REG_IDX;
  assign is_reg = (idx == REG_IDX) && (off == OFF_PEND || off == OFF_MASK);
  assign done   = busy && cnt == (we_q ? WR_LAST : RD_LAST);

  assign stall    = req & ~done;
  assign err      = done & ~(is_ch | is_reg);
  assign rdata    = rd_q;
  assign ch_we    = we_q;
  assign ch_addr  = off;
  assign ch_wdata = wd_q;
  assign irq      = |(pend & mask);

  for (genvar g = 0; g < NCH; g++) begin : g_en
    assign ch_en[g] = busy && idx == IDXW'(g);
  end

  always_comb begin
    sel = '0;
    for (int i = 0; i < NCH; i++)
      if (idx == IDXW'(i)) sel = ch_rdata[i*DW +: DW];
    regval = '0;
    if (is_reg) regval = (off == OFF_PEND) ? DW'(pend) : DW'(mask);
  end

  assign clr = (done && we_q && is_reg && off == OFF_PEND) ? wd_q[NCH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      a_q  <= '0;
      we_q <= 1'b0;
      wd_q <= '0;
      rd_q <= '0;
      pend <= '0;
      mask <= '1;
    end else begin
      if (!busy) begin
        if (req) begin
          busy <= 1'b1;
          cnt  <= '0;
          a_q  <= addr;
          we_q <= we;
          wd_q <= wdata;
        end
      end else if (done) begin
        busy <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
      if (busy && !we_q && cnt == RD_CAPT) rd_q <= is_ch ? sel : regval;
      if (done && we_q && is_reg && off == OFF_MASK) mask <= wd_q[NCH-1:0];
      pend <= (pend & ~clr) | ch_irq;
    end
  end
endmodule

// File: rtl/chan_select_adapter_chk.sv
module chan_select_adapter_chk #(
  parameter int NCH      = 4,
  parameter int WIN_BITS = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req,
  input logic                stall,
  input logic                err,
  input logic                irq,
  input logic [NCH-1:0]      ch_en,
  input logic                ch_we,
  input logic [WIN_BITS-1:0] ch_addr,
  input logic [NCH-1:0]      ch_irq,
  input logic [NCH-1:0]      mask
);
  assert_onehot_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_en));

  assert_err_no_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (ch_en == '0));

  assert_err_final_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (req && !stall));

  assert_stable_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ch_en) && $past(|ch_en)) |-> ($stable(ch_addr) && $stable(ch_we) && $stable(ch_en)));

  assert_irq_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ch_irq & mask)) |=> (irq || mask != $past(mask)));
endmodule

bind chan_select_adapter chan_select_adapter_chk #(.NCH(NCH), .WIN_BITS(WIN_BITS)) u_chk (.*);

// File: tb/test_chan_select_adapter.sv
`timescale 1ns/1ps
module test_chan_select_adapter;
  localparam int AW = 8, DW = 16, NCH = 4, WB = 4;
  localparam int VW = 45;
  localparam int NV = 8;
  // {we, addr, wdata, exp_rdata, exp_err, exp_idx(7 = none)}
  localparam logic [VW-1:0] VEC [0:NV-1] = '{
    {1'b1, 8'h03, 16'h1111, 16'h0000, 1'b0, 3'd0},
    {1'b1, 8'h3F, 16'hBEEF, 16'h0000, 1'b0, 3'd3},
    {1'b0, 8'h25, 16'h0000, 16'hC205, 1'b0, 3'd2},
    {1'b0, 8'h10, 16'h0000, 16'hC100, 1'b0, 3'd1},
    {1'b0, 8'h9A, 16'h0000, 16'h0000, 1'b1, 3'd7},
    {1'b1, 8'h48, 16'h00FF, 16'h0000, 1'b1, 3'd7},
    {1'b0, 8'h44, 16'h0000, 16'h000F, 1'b0, 3'd7},
    {1'b0, 8'h40, 16'h0000, 16'h0000, 1'b0, 3'd7}
  };

  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata, ch_wdata;
  logic stall, err, irq, ch_we;
  logic [NCH-1:0] ch_en, ch_irq = '0;
  logic [WB-1:0] ch_addr;
  logic [NCH*DW-1:0] ch_rdata;
  int n_chk = 0, n_fail = 0;
  int cyc;
  logic [DW-1:0] got_rd;
  logic got_err;
  logic [NCH-1:0] en_seen;
  logic wr_ok;

  always #2 clk = ~clk;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign ch_rdata[g*DW +: DW] = {4'hC, 4'(g), 4'h0, ch_addr};
  end

  chan_select_adapter #(.AW(AW), .DW(DW), .NCH(NCH), .WIN_BITS(WB)) i_chan_select_adapter (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .stall(stall), .err(err), .irq(irq), .ch_en(ch_en),
    .ch_we(ch_we), .ch_addr(ch_addr), .ch_wdata(ch_wdata), .ch_rdata(ch_rdata),
    .ch_irq(ch_irq));

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req = 1; we = w; addr = a; wdata = d;
    #1;
    cyc = 1; en_seen = '0; wr_ok = 1;
    while (stall && cyc < 50) begin
      @(negedge clk); #1;
      cyc++;
      en_seen |= ch_en;
      if (|ch_en && w && (ch_wdata != d || ch_addr != a[WB-1:0] || !ch_we)) wr_ok = 0;
    end
    got_rd = rdata; got_err = err;
    @(negedge clk);
    req = 0;
  endtask

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(ch_en == 0 && !stall && !err && !irq, "R9 reset outputs",
        {ch_en, stall, err, irq}, 0);
    rst_n = 1;
    access(0, 8'h40, 0);
    chk(got_rd == 0, "R9 pending zero after reset", got_rd, 0);

    for (int v = 0; v < NV; v++) begin
      logic [VW-1:0] e;
      logic [NCH-1:0] exp_en;
      e = VEC[v];
      access(e[44], e[43:36], e[35:20]);
      exp_en = (e[2:0] == 3'd7) ? '0 : NCH'(1) << e[2:0];
      chk(cyc == (e[44] ? 3 : 7), e[44] ? "R3 write length" : "R4 read length", cyc, e[44] ? 3 : 7);
      chk(got_err == e[3], "R2 error flag", got_err, e[3]);
      chk(en_seen == exp_en, "R1 enable select", en_seen, exp_en);
      if (e[44]) chk(wr_ok, "R5 channel write fields", wr_ok, 1);
      else if (!e[3]) chk(got_rd == e[19:4], "R4 read data", got_rd, e[19:4]);
    end

    @(negedge clk); ch_irq = 4'b0010;
    @(negedge clk); ch_irq = 4'b0000;
    #1;
    chk(irq == 1, "R8 irq from unmasked pending", irq, 1);
    access(0, 8'h40, 0);
    chk(got_rd == 16'h0002, "R6 pending read", got_rd, 16'h0002);
    access(1, 8'h44, 16'h000D);
    #1;
    chk(irq == 0, "R8 masked pending gives no irq", irq, 0);
    access(0, 8'h44, 0);
    chk(got_rd == 16'h000D, "R8 mask readback", got_rd, 16'h000D);
    access(1, 8'h44, 16'h000F);
    #1;
    chk(irq == 1, "R8 unmask restores irq", irq, 1);
    @(negedge clk); ch_irq = 4'b1000;
    @(negedge clk); ch_irq = 4'b0000;
    access(1, 8'h40, 16'h0002);
    access(0, 8'h40, 0);
    chk(got_rd == 16'h0008, "R7 write-one-to-clear keeps others", got_rd, 16'h0008);
    chk(irq == 1, "R7 irq remains for bit 3", irq, 1);
    access(1, 8'h40, 16'hFFFF);
    #1;
    chk(irq == 0, "R7 clear all drops irq", irq, 0);
    access(0, 8'h40, 0);
    chk(got_rd == 0, "R7 pending empty", got_rd, 0);
    access(0, 8'h50, 0);
    chk(got_err && en_seen == 0, "R2 index above register window", {got_err, en_seen}, 5'h10);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule